// File: doc/BRIEF.md
# Legacy-Aware Timer Interrupt Router

This block sits between a three-channel event-timer unit and the interrupt controllers of a PC-style platform. Each timer raises a one-cycle expiry strobe. The router turns that strobe into a single-cycle pulse on one of 24 interrupt-controller inputs. It picks the ISA-style line for each timer from one of two sources. In legacy replacement mode, timers 0 and 1 take fixed lines. Otherwise every timer uses its own five-bit route field. The router then moves the chosen ISA line onto the advanced interrupt controller's input numbering.

While legacy replacement mode is on, the event timers take over the job of the old interval timer (channel 0) and the real-time clock. The router therefore also filters those older sources. The interval timer request is muted. The real-time clock cannot raise a new request, but it can still drop one that is already raised. Its periodic source is held off. When legacy mode ends, the router issues a one-cycle reload command. This command restarts interval-timer channel 0 in square-wave mode with its gate high and a reload count of zero.

All outputs are registered. Each one reflects the inputs sampled at the previous rising clock edge.

Top module: `legacy_irq_router`

## Requirements
- R1: While `legacy_mode` is 1, timer 0 drives ISA IRQ0 and timer 1 drives ISA IRQ8, whatever their route fields hold.
- R2: When legacy mode is off, each timer's ISA line comes from its route field. Timer 2 always uses its route field. The field for timer t is `tmr_route[5t+4:5t]`.
- R3: A timer produces a pulse only when its `tmr_fire` strobe, its own `tmr_enable` bit and `glb_enable` are all 1 in the same cycle.
- R4: ISA IRQ0 lands on bit 2 of `irq_pulse`. Every other ISA line n lands on bit n. Bit 0 of `irq_pulse` never pulses.
- R5: A route field value of 24 or more is ignored. The timer produces no pulse anywhere.
- R6: A qualifying strobe sampled at one rising edge makes its `irq_pulse` bit high for exactly the following cycle. Timers that resolve to the same input merge into that one bit.
- R7: `pit_irq` follows `pit_req` with one cycle of latency when legacy mode is off. It is 0 in the cycle after any cycle in which legacy mode is on.
- R8: When `legacy_mode` is sampled 0 after having been sampled 1 at the previous edge, the next cycle carries a reload command. That command has `pit_reload_valid`=1, mode 3, `pit_reload_gate`=1 and count 0. In every other cycle, all four reload outputs are 0.
- R9: `rtc_irq` goes low one cycle after `rtc_req` is low, even in legacy mode. It rises only when `rtc_req` is high and legacy mode is off. A request raised before legacy mode began stays high while `rtc_req` stays high.
- R10: `rtc_periodic_out` follows `rtc_periodic_req` with one cycle of latency, and it is forced to 0 after any cycle with legacy mode on.
- R11: A synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_enable | input | 1 | Global interrupt generation enable |
| legacy_mode | input | 1 | Legacy replacement routing active |
| tmr_fire | input | 3 | Per-timer expiry strobes |
| tmr_enable | input | 3 | Per-timer interrupt enable bits |
| tmr_route | input | 15 | Route fields, five bits per timer, timer 0 in the low bits |
| pit_req | input | 1 | Raw interval-timer channel 0 request |
| rtc_req | input | 1 | Raw real-time-clock interrupt request level |
| rtc_periodic_req | input | 1 | Raw real-time-clock periodic source |
| irq_pulse | output | 24 | Interrupt-controller input pulses |
| pit_irq | output | 1 | Gated interval-timer request |
| rtc_irq | output | 1 | Gated real-time-clock request |
| rtc_periodic_out | output | 1 | Gated periodic source |
| pit_reload_valid | output | 1 | Reload command strobe for interval-timer channel 0 |
| pit_reload_mode | output | 3 | Counting mode carried by the reload command |
| pit_reload_gate | output | 1 | Gate level carried by the reload command |
| pit_reload_count | output | 16 | Reload count carried by the reload command |

## Verification
The reload-command assertion assumes that `legacy_mode` is held low while `rst` is asserted. If it were held high, a mode exit on the first cycle after reset would go unseen, because the stored copy of the mode bit starts at 0. The pulse assertions place no limit on how often the strobes fire. Back-to-back strobes may therefore hold a line high for several cycles.

The stimulus releases reset with every input low. Legacy mode is switched only after reset. Route fields are driven across the whole five-bit range, so out-of-range values are exercised next to legal ones.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int NUM_TIMERS_DEF   = 3;
    localparam int NUM_LINES_DEF    = 24;
    localparam int ROUTE_W_DEF      = 5;

    localparam int LEGACY_T0_ISA    = 0;
    localparam int LEGACY_T1_ISA    = 8;
    localparam int ISA0_APIC_INPUT  = 2;

    localparam int PIT_MODE_W       = 3;
    localparam int PIT_CNT_W        = 16;
    localparam int PIT_RESTART_MODE = 3;
    localparam int PIT_RESTART_CNT  = 0;

    typedef struct packed {
        logic                  valid;
        logic [PIT_MODE_W-1:0] mode;
        logic                  gate;
        logic [PIT_CNT_W-1:0]  count;
    } pit_reload_t;

    typedef enum logic [1:0] {
        SRC_ROUTE  = 2'd0,
        SRC_LEG_T0 = 2'd1,
        SRC_LEG_T1 = 2'd2
    } line_src_e;

endpackage

// File: rtl/tmr_line_select.sv
module tmr_line_select
    import irq_route_pkg::*;
#(
    parameter int TIMER_IDX = 0,
    parameter int ROUTE_W   = ROUTE_W_DEF,
    parameter int NUM_LINES = NUM_LINES_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic               tmr_en,
    input  logic               glb_en,
    input  logic               legacy,
    input  logic [ROUTE_W-1:0] route,
    output logic               sel_valid,
    output logic [ROUTE_W-1:0] sel_line
);
    localparam logic [ROUTE_W-1:0] LEG_T0_LINE = ROUTE_W'(LEGACY_T0_ISA);
    localparam logic [ROUTE_W-1:0] LEG_T1_LINE = ROUTE_W'(LEGACY_T1_ISA);

    line_src_e src;
    logic      armed;

    always_comb begin
        src = SRC_ROUTE;
        if (legacy) begin
            if (TIMER_IDX == 0)      src = SRC_LEG_T0;
            else if (TIMER_IDX == 1) src = SRC_LEG_T1;
        end
    end

    always_comb begin
        unique case (src)
            SRC_LEG_T0: sel_line = LEG_T0_LINE;
            SRC_LEG_T1: sel_line = LEG_T1_LINE;
            default:    sel_line = route;
        endcase
    end

    assign armed     = fire & tmr_en & glb_en;
    assign sel_valid = armed && (int'(sel_line) < NUM_LINES);

    generate
        if (TIMER_IDX == 0) begin : g_leg0_chk
            AST_LEGACY_T0_LINE: assert property (@(posedge clk) disable iff (rst)
                (legacy && armed) |-> (sel_valid && sel_line == LEG_T0_LINE)); // R1
        end else if (TIMER_IDX == 1) begin : g_leg1_chk
            AST_LEGACY_T1_LINE: assert property (@(posedge clk) disable iff (rst)
                (legacy && armed) |-> (sel_valid && sel_line == LEG_T1_LINE)); // R1
        end
    endgenerate

    AST_DISARMED_SILENT: assert property (@(posedge clk) disable iff (rst)
        !(fire && tmr_en && glb_en) |-> !sel_valid); // R3

    AST_ROUTE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (!legacy && int'(route) >= NUM_LINES) |-> !sel_valid); // R5

endmodule

// File: rtl/irq_pulse_merge.sv
module irq_pulse_merge
    import irq_route_pkg::*;
#(
    parameter int NUM_TIMERS = NUM_TIMERS_DEF,
    parameter int NUM_LINES  = NUM_LINES_DEF,
    parameter int ROUTE_W    = ROUTE_W_DEF
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_TIMERS-1:0]         sel_valid,
    input  logic [NUM_TIMERS*ROUTE_W-1:0] sel_line,
    output logic [NUM_LINES-1:0]          irq_pulse
);
    localparam logic [ROUTE_W-1:0] ISA0_TARGET = ROUTE_W'(ISA0_APIC_INPUT);

    logic [ROUTE_W-1:0]   apic_idx [NUM_TIMERS];
    logic [NUM_LINES-1:0] hit;

    genvar t, l;
    generate
        for (t = 0; t < NUM_TIMERS; t++) begin : g_map
            logic [ROUTE_W-1:0] isa;
            assign isa         = sel_line[t*ROUTE_W +: ROUTE_W];
            assign apic_idx[t] = (isa == '0) ? ISA0_TARGET : isa;
        end

        for (l = 0; l < NUM_LINES; l++) begin : g_line
            always_comb begin
                hit[l] = 1'b0;
                for (int k = 0; k < NUM_TIMERS; k++) begin
                    if (sel_valid[k] && int'(apic_idx[k]) == l) hit[l] = 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) irq_pulse <= '0;
        else     irq_pulse <= hit;
    end

    AST_APIC0_IDLE: assert property (@(posedge clk) disable iff (rst)
        irq_pulse[0] == 1'b0); // R4

    AST_NO_SEL_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (sel_valid == '0) |=> (irq_pulse == '0)); // R6

    AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_pulse) <= NUM_TIMERS); // R6

endmodule

// File: rtl/legacy_src_gate.sv
module legacy_src_gate
    import irq_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        legacy,
    input  logic        pit_req,
    input  logic        rtc_req,
    input  logic        rtc_periodic_req,
    output logic        pit_irq,
    output logic        rtc_irq,
    output logic        rtc_periodic_out,
    output pit_reload_t reload
);
    logic legacy_q;
    logic leaving;

    assign leaving = legacy_q & ~legacy;

    always_ff @(posedge clk) begin
        if (rst) begin
            legacy_q         <= 1'b0;
            pit_irq          <= 1'b0;
            rtc_irq          <= 1'b0;
            rtc_periodic_out <= 1'b0;
            reload           <= '0;
        end else begin
            legacy_q         <= legacy;
            pit_irq          <= pit_req & ~legacy;
            rtc_irq          <= rtc_req & (rtc_irq | ~legacy);
            rtc_periodic_out <= rtc_periodic_req & ~legacy;
            reload.valid     <= leaving;
            reload.mode      <= leaving ? PIT_MODE_W'(PIT_RESTART_MODE) : '0;
            reload.gate      <= leaving;
            reload.count     <= PIT_CNT_W'(PIT_RESTART_CNT);
        end
    end

    AST_PIT_MUTED: assert property (@(posedge clk) disable iff (rst)
        legacy |=> !pit_irq); // R7

    AST_RELOAD_ON_EXIT: assert property (@(posedge clk) disable iff (rst)
        ($fell(legacy) && !$past(rst)) |=> (reload.valid && reload.gate
                                            && reload.mode == PIT_MODE_W'(PIT_RESTART_MODE))); // R8

    AST_RELOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reload.valid |=> !reload.valid); // R8

    AST_RTC_NO_RAISE: assert property (@(posedge clk) disable iff (rst)
        (legacy && !rtc_irq) |=> !rtc_irq); // R9

    AST_RTC_LOWER: assert property (@(posedge clk) disable iff (rst)
        !rtc_req |=> !rtc_irq); // R9

    AST_PERIODIC_HELD: assert property (@(posedge clk) disable iff (rst)
        legacy |=> !rtc_periodic_out); // R10

endmodule

// File: rtl/legacy_irq_router.sv
module legacy_irq_router
    import irq_route_pkg::*;
#(
    parameter int NUM_TIMERS = NUM_TIMERS_DEF,
    parameter int NUM_LINES  = NUM_LINES_DEF,
    parameter int ROUTE_W    = ROUTE_W_DEF
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          glb_enable,
    input  logic                          legacy_mode,
    input  logic [NUM_TIMERS-1:0]         tmr_fire,
    input  logic [NUM_TIMERS-1:0]         tmr_enable,
    input  logic [NUM_TIMERS*ROUTE_W-1:0] tmr_route,
    input  logic                          pit_req,
    input  logic                          rtc_req,
    input  logic                          rtc_periodic_req,
    output logic [NUM_LINES-1:0]          irq_pulse,
    output logic                          pit_irq,
    output logic                          rtc_irq,
    output logic                          rtc_periodic_out,
    output logic                          pit_reload_valid,
    output logic [PIT_MODE_W-1:0]         pit_reload_mode,
    output logic                          pit_reload_gate,
    output logic [PIT_CNT_W-1:0]          pit_reload_count
);
    logic [NUM_TIMERS-1:0]         sel_valid;
    logic [NUM_TIMERS*ROUTE_W-1:0] sel_line;
    pit_reload_t                   reload;

    genvar t;
    generate
        for (t = 0; t < NUM_TIMERS; t++) begin : g_tmr
            tmr_line_select #(
                .TIMER_IDX (t),
                .ROUTE_W   (ROUTE_W),
                .NUM_LINES (NUM_LINES)
            ) u_sel (
                .clk       (clk),
                .rst       (rst),
                .fire      (tmr_fire[t]),
                .tmr_en    (tmr_enable[t]),
                .glb_en    (glb_enable),
                .legacy    (legacy_mode),
                .route     (tmr_route[t*ROUTE_W +: ROUTE_W]),
                .sel_valid (sel_valid[t]),
                .sel_line  (sel_line[t*ROUTE_W +: ROUTE_W])
            );
        end
    endgenerate

    irq_pulse_merge #(
        .NUM_TIMERS (NUM_TIMERS),
        .NUM_LINES  (NUM_LINES),
        .ROUTE_W    (ROUTE_W)
    ) u_merge (
        .clk       (clk),
        .rst       (rst),
        .sel_valid (sel_valid),
        .sel_line  (sel_line),
        .irq_pulse (irq_pulse)
    );

    legacy_src_gate u_gate (
        .clk              (clk),
        .rst              (rst),
        .legacy           (legacy_mode),
        .pit_req          (pit_req),
        .rtc_req          (rtc_req),
        .rtc_periodic_req (rtc_periodic_req),
        .pit_irq          (pit_irq),
        .rtc_irq          (rtc_irq),
        .rtc_periodic_out (rtc_periodic_out),
        .reload           (reload)
    );

    assign pit_reload_valid = reload.valid;
    assign pit_reload_mode  = reload.mode;
    assign pit_reload_gate  = reload.gate;
    assign pit_reload_count = reload.count;

    AST_GLOBAL_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !glb_enable |=> (irq_pulse == '0)); // R3

    AST_LEGACY_IRQ0_TARGET: assert property (@(posedge clk) disable iff (rst)
        (legacy_mode && glb_enable && tmr_fire[0] && tmr_enable[0])
            |=> irq_pulse[ISA0_APIC_INPUT]); // R4

    AST_RELOAD_COUNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        pit_reload_count == '0); // R8

endmodule

// File: tb/tb_legacy_irq_router.sv
`timescale 1ns/1ps
module tb_legacy_irq_router;

    localparam int NT = 3;
    localparam int NL = 24;
    localparam int RW = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            glb_enable = 1'b0;
    logic            legacy_mode = 1'b0;
    logic [NT-1:0]   tmr_fire = '0;
    logic [NT-1:0]   tmr_enable = '0;
    logic [NT*RW-1:0] tmr_route = '0;
    logic            pit_req = 1'b0;
    logic            rtc_req = 1'b0;
    logic            rtc_periodic_req = 1'b0;

    logic [NL-1:0]   irq_pulse;
    logic            pit_irq, rtc_irq, rtc_periodic_out;
    logic            pit_reload_valid, pit_reload_gate;
    logic [2:0]      pit_reload_mode;
    logic [15:0]     pit_reload_count;

    legacy_irq_router dut (
        .clk(clk), .rst(rst), .glb_enable(glb_enable), .legacy_mode(legacy_mode),
        .tmr_fire(tmr_fire), .tmr_enable(tmr_enable), .tmr_route(tmr_route),
        .pit_req(pit_req), .rtc_req(rtc_req), .rtc_periodic_req(rtc_periodic_req),
        .irq_pulse(irq_pulse), .pit_irq(pit_irq), .rtc_irq(rtc_irq),
        .rtc_periodic_out(rtc_periodic_out), .pit_reload_valid(pit_reload_valid),
        .pit_reload_mode(pit_reload_mode), .pit_reload_gate(pit_reload_gate),
        .pit_reload_count(pit_reload_count)
    );

    always #2 clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference, updated at every rising edge
    logic [NL-1:0] e_irq = '0;
    bit e_pit = 0, e_rtc = 0, e_per = 0, e_rv = 0, prev_leg = 0;

    always @(posedge clk) begin
        logic [NL-1:0] v;
        cycles++;
        if (rst) begin
            e_irq <= '0; e_pit <= 0; e_rtc <= 0; e_per <= 0; e_rv <= 0; prev_leg <= 0;
        end else begin
            v = '0;
            for (int t = 0; t < NT; t++) begin
                int isa;
                isa = int'(tmr_route[t*RW +: RW]);
                if (legacy_mode && t == 0) isa = 0;
                if (legacy_mode && t == 1) isa = 8;
                if (tmr_fire[t] && tmr_enable[t] && glb_enable && isa < NL)
                    v[(isa == 0) ? 2 : isa] = 1'b1;
            end
            e_irq    <= v;
            e_pit    <= pit_req && !legacy_mode;
            e_rtc    <= rtc_req ? (e_rtc || !legacy_mode) : 1'b0;
            e_per    <= rtc_periodic_req && !legacy_mode;
            e_rv     <= prev_leg && !legacy_mode;
            prev_leg <= legacy_mode;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cycles, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R1 R2 R3 R4 R5 R6 R11 irq_pulse", 32'(irq_pulse), 32'(e_irq));
        check("R7 pit_irq", 32'(pit_irq), 32'(e_pit));
        check("R9 rtc_irq", 32'(rtc_irq), 32'(e_rtc));
        check("R10 rtc_periodic_out", 32'(rtc_periodic_out), 32'(e_per));
        check("R8 reload_valid", 32'(pit_reload_valid), 32'(e_rv));
        check("R8 reload_mode", 32'(pit_reload_mode), e_rv ? 32'd3 : 32'd0);
        check("R8 reload_gate", 32'(pit_reload_gate), 32'(e_rv));
        check("R8 reload_count", 32'(pit_reload_count), 32'd0);
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    function automatic logic [NT*RW-1:0] routes(int r0, int r1, int r2);
        return {RW'(r2), RW'(r1), RW'(r0)};
    endfunction

    task automatic fire(logic [NT-1:0] f);
        tmr_fire = f;
        tick();
        tmr_fire = '0;
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(3);                                    // R11 reset state
        rst = 0;
        tick();
        glb_enable = 1; tmr_enable = '1;
        tmr_route = routes(5, 10, 11);
        fire(3'b001); fire(3'b010); fire(3'b111);   // R2 R6
        tmr_route = routes(7, 7, 7);
        fire(3'b111);                               // R6 merge
        tmr_route = routes(0, 1, 23);
        fire(3'b111);                               // R4 IRQ0 to input 2, R5 edge
        tmr_route = routes(24, 31, 30);
        fire(3'b111);                               // R5
        glb_enable = 0; tmr_route = routes(4, 6, 9);
        fire(3'b111);                               // R3 global off
        glb_enable = 1; tmr_enable = 3'b010;
        fire(3'b111);                               // R3 timer enable
        tmr_enable = '1;
        tmr_fire = 3'b111; tick(3); tmr_fire = '0; tick();  // R6 back-to-back
        rtc_req = 1; pit_req = 1; rtc_periodic_req = 1; tick(2);
        legacy_mode = 1; tmr_route = routes(20, 21, 12);
        fire(3'b111);                               // R1
        tick(2);                                    // R7 R9 R10 held
        rtc_req = 0; tick(2);                       // R9 lower passes
        rtc_req = 1; tick(2);                       // R9 raise blocked
        legacy_mode = 0; tick(3);                   // R8 reload, R9 raise again
        legacy_mode = 1; tick(); legacy_mode = 0; tick(2);  // R8 short visit
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0) legacy_mode = ~legacy_mode;
            glb_enable       = ($urandom_range(0, 7) != 0);
            tmr_enable       = NT'($urandom);
            tmr_fire         = NT'($urandom);
            tmr_route        = (NT*RW)'($urandom);
            pit_req          = $urandom_range(0, 1) == 1;
            rtc_req          = $urandom_range(0, 3) != 0;
            rtc_periodic_req = $urandom_range(0, 1) == 1;
            tick();
        end
        rst = 1; tick(2);                           // R11 mid-run reset
        finish_run();
    end

endmodule